// File: doc/BRIEF.md
# PCM Time-Slot Serial Interface

This block is the digital framing and serial port of one voice-band PCM channel. Its transmit direction takes an 8-bit parallel sample and shifts it out, most significant bit first, during its time slot. Its receive direction assembles an 8-bit serial word into a parallel register and flags it. The two directions run independently. Each has its own frame sync, its own data clock in variable-rate mode, its own standby timer and its own signaling path.

In fixed-rate mode the master clock also serves as the data clock. A frame-sync pulse one data-clock period long opens a normal slot. A pulse two periods long opens a signaling slot: transmit replaces the least significant bit with a signaling input, and receive keeps the least significant bit on a held signaling output. In variable-rate mode each direction uses its own data clock, and a time-slot enable level covers the whole slot.

All inputs are sampled into one system-clock domain through two-flop synchronizers. Edges of the data clocks are detected in that domain. The system clock must therefore run several times faster than any data clock.

Top module: `pcm_slot_port`

## Requirements
- R1: A transmit slot drives the 8 bits of the sample latched at the slot's first data-clock rising edge onto `tx_serial`, MSB first, one bit per rising edge. `tx_oe` is high for exactly those eight bit periods and falls at the ninth rising edge.
- R2: A receive slot samples `rx_serial` on eight consecutive data-clock falling edges, MSB first. It presents the word on `rx_word` and pulses `rx_valid` for one system clock after the eighth bit.
- R3: In fixed-rate mode (`rate_var` = 0), the sync level at the second data-clock edge of a slot sets the frame type: low means a normal frame, high means a signaling frame. In a transmit signaling frame, bit 0 (the last bit sent) carries the level of `tx_sig` instead of the sample's bit 0. In a normal frame, `tx_sig` has no effect.
- R4: `rx_sig` takes bit 0 of the word received in each signaling frame. It keeps that value through normal frames.
- R5: In variable-rate mode (`rate_var` = 1), `tx_dclk` and `rx_dclk` are the data clocks. The sync inputs act as enables that are high across the slot. No signaling substitution takes place, and `tx_strobe_n` stays high.
- R6: In fixed-rate mode, `tx_strobe_n` is low during exactly the window in which `tx_oe` is high.
- R7: `tx_load` pulses for one system clock at the start of each transmit slot, and at no other time.
- R8: Each direction raises its own standby output after its sync input has stayed low for IDLE_LIMIT master-clock rising edges. A high sync input clears that direction's standby and nothing else.
- R9: While `pwr_en` is low, both directions are inactive: no slot starts, `tx_oe` stays low, and `rx_valid` and `tx_load` stay low. Normal operation returns when `pwr_en` goes high.
- R10: After reset, `tx_oe`, `tx_load`, `rx_valid`, `rx_sig`, both standby outputs and `rx_word` are 0, and `tx_strobe_n` is 1.
- R11: A new slot starts only after the sync input has been seen low at a data-clock edge. A sync level held high past the eighth bit does not start a second slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_var | input | 1 | 0 = fixed-rate mode, 1 = variable-rate mode |
| pwr_en | input | 1 | Active high; low powers both directions down |
| mclk | input | 1 | Master clock; the data clock in fixed-rate mode |
| tx_dclk | input | 1 | Transmit data clock in variable-rate mode |
| rx_dclk | input | 1 | Receive data clock in variable-rate mode |
| tx_fsync | input | 1 | Transmit frame sync / time-slot enable |
| rx_fsync | input | 1 | Receive frame sync / time-slot enable |
| tx_sig | input | 1 | Signaling bit sent in transmit signaling frames |
| tx_sample | input | 8 | Parallel sample to transmit |
| tx_serial | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Drive enable for `tx_serial` |
| tx_strobe_n | output | 1 | Active-low time-slot strobe (fixed-rate mode) |
| tx_load | output | 1 | One-cycle request for the next sample |
| rx_serial | input | 1 | Serial receive data |
| rx_word | output | 8 | Last received word |
| rx_valid | output | 1 | One-cycle pulse when `rx_word` updates |
| rx_sig | output | 1 | Bit 0 from the latest receive signaling frame |
| tx_standby | output | 1 | Transmit direction idle past the limit |
| rx_standby | output | 1 | Receive direction idle past the limit |

## Verification
The properties assume that every data clock stays high and low for at least three system clocks. They also assume that sync and serial data inputs change well away from the data-clock edge that samples them, and that `rate_var` does not change during a slot. The stimulus runs the master clock at sixteen system clocks per period and the variable-rate data clock at twenty. It moves sync a quarter period before a rising edge and receive data a quarter period after one, and it switches mode only while both directions are idle. The power-down property assumes `pwr_en` stays low for three samples, which the stimulus holds far longer.

// File: rtl/pcm_slot_pkg.sv
`timescale 1ns/1ps
package pcm_slot_pkg;
  localparam int PCM_W = 8;
  typedef logic [PCM_W-1:0] pcm_word_t;
  typedef enum logic { RATE_FIXED = 1'b0, RATE_VAR = 1'b1 } rate_e;
endpackage

// File: rtl/pcm_sync_edge.sv
`timescale 1ns/1ps
module pcm_sync_edge #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] level,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] pipe [0:STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i <= STAGES; i++) pipe[i] <= '0;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i <= STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign level = pipe[STAGES-1];
  assign rise  = pipe[STAGES-1] & ~pipe[STAGES];
  assign fall  = ~pipe[STAGES-1] & pipe[STAGES];
endmodule

// File: rtl/pcm_tx_lane.sv
`timescale 1ns/1ps
module pcm_tx_lane #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              fixed_mode,
  input  logic              bit_edge,
  input  logic              fs,
  input  logic              sig_in,
  input  logic [WORD_W-1:0] sample,
  output logic              serial,
  output logic              oe,
  output logic              strobe_n,
  output logic              load
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] IDX_SIG  = CNT_W'(1);
  localparam logic [CNT_W-1:0] IDX_LSB  = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] IDX_DONE = CNT_W'(WORD_W);

  logic              active, armed, sig_frame;
  logic [CNT_W-1:0]  idx;
  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      active <= 1'b0; armed <= 1'b0; sig_frame <= 1'b0; idx <= '0;
      shreg <= '0; serial <= 1'b0; oe <= 1'b0; strobe_n <= 1'b1; load <= 1'b0;
    end else begin
      load <= 1'b0;
      if (bit_edge) begin
        if (!fs) armed <= 1'b1;
        if (!active) begin
          if (fs && armed) begin
            active    <= 1'b1;
            armed     <= 1'b0;
            sig_frame <= 1'b0;
            idx       <= IDX_SIG;
            serial    <= sample[WORD_W-1];
            shreg     <= {sample[WORD_W-2:0], 1'b0};
            oe        <= 1'b1;
            strobe_n  <= ~fixed_mode;
            load      <= 1'b1;
          end
        end else if (idx == IDX_DONE) begin
          active   <= 1'b0;
          oe       <= 1'b0;
          strobe_n <= 1'b1;
        end else begin
          if (idx == IDX_SIG) sig_frame <= fixed_mode && fs;
          serial <= (idx == IDX_LSB && sig_frame) ? sig_in : shreg[WORD_W-1];
          shreg  <= {shreg[WORD_W-2:0], 1'b0};
          idx    <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_rx_lane.sv
`timescale 1ns/1ps
module pcm_rx_lane #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              fixed_mode,
  input  logic              bit_edge,
  input  logic              fs,
  input  logic              sdata,
  output logic [WORD_W-1:0] word,
  output logic              valid,
  output logic              sig_out
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] IDX_SIG = CNT_W'(1);
  localparam logic [CNT_W-1:0] IDX_LSB = CNT_W'(WORD_W - 1);

  logic              active, armed, sig_frame;
  logic [CNT_W-1:0]  idx;
  logic [WORD_W-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
      sig_out <= 1'b0;
    end else if (en && bit_edge && active && idx == IDX_LSB) begin
      word <= {shreg[WORD_W-2:0], sdata};
      if (sig_frame) sig_out <= sdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      active <= 1'b0; armed <= 1'b0; sig_frame <= 1'b0;
      idx <= '0; shreg <= '0; valid <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (bit_edge) begin
        if (!fs) armed <= 1'b1;
        if (!active) begin
          if (fs && armed) begin
            active    <= 1'b1;
            armed     <= 1'b0;
            sig_frame <= 1'b0;
            idx       <= IDX_SIG;
            shreg     <= {shreg[WORD_W-2:0], sdata};
          end
        end else begin
          if (idx == IDX_SIG) sig_frame <= fixed_mode && fs;
          shreg <= {shreg[WORD_W-2:0], sdata};
          if (idx == IDX_LSB) begin
            active <= 1'b0;
            valid  <= 1'b1;
          end else begin
            idx <= idx + 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/pcm_idle_timer.sv
`timescale 1ns/1ps
module pcm_idle_timer #(
  parameter int LIMIT = 614400
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic fs,
  output logic standby
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || fs) begin
      cnt     <= '0;
      standby <= 1'b0;
    end else begin
      if (tick && cnt != TOP) cnt <= cnt + 1'b1;
      standby <= (cnt == TOP);
    end
  end
endmodule

// File: rtl/pcm_slot_port.sv
`timescale 1ns/1ps
module pcm_slot_port
  import pcm_slot_pkg::*;
#(
  parameter int IDLE_LIMIT  = 614400,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rate_var,
  input  logic             pwr_en,
  input  logic             mclk,
  input  logic             tx_dclk,
  input  logic             rx_dclk,
  input  logic             tx_fsync,
  input  logic             rx_fsync,
  input  logic             tx_sig,
  input  logic [PCM_W-1:0] tx_sample,
  output logic             tx_serial,
  output logic             tx_oe,
  output logic             tx_strobe_n,
  output logic             tx_load,
  input  logic             rx_serial,
  output logic [PCM_W-1:0] rx_word,
  output logic             rx_valid,
  output logic             rx_sig,
  output logic             tx_standby,
  output logic             rx_standby
);
  localparam int N_IN = 8;
  localparam int I_MCLK = 0, I_TXC = 1, I_RXC = 2, I_TXF = 3;
  localparam int I_RXF = 4, I_SIG = 5, I_RXD = 6, I_PWR = 7;

  logic [N_IN-1:0] raw, lvl, rise, fall;
  assign raw = {pwr_en, rx_serial, tx_sig, rx_fsync, tx_fsync, rx_dclk, tx_dclk, mclk};

  pcm_sync_edge #(.W(N_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw), .level(lvl), .rise(rise), .fall(fall)
  );

  logic fixed_mode, tx_edge, rx_edge;
  assign fixed_mode = (rate_rate_e(rate_var) == RATE_FIXED);
  assign tx_edge    = fixed_mode ? rise[I_MCLK] : rise[I_TXC];
  assign rx_edge    = fixed_mode ? fall[I_MCLK] : fall[I_RXC];

  function automatic rate_e rate_rate_e(input logic v);
    return v ? RATE_VAR : RATE_FIXED;
  endfunction

  pcm_tx_lane #(.WORD_W(PCM_W)) u_tx (
    .clk(clk), .rst(rst), .en(lvl[I_PWR]), .fixed_mode(fixed_mode),
    .bit_edge(tx_edge), .fs(lvl[I_TXF]), .sig_in(lvl[I_SIG]), .sample(tx_sample),
    .serial(tx_serial), .oe(tx_oe), .strobe_n(tx_strobe_n), .load(tx_load)
  );

  pcm_rx_lane #(.WORD_W(PCM_W)) u_rx (
    .clk(clk), .rst(rst), .en(lvl[I_PWR]), .fixed_mode(fixed_mode),
    .bit_edge(rx_edge), .fs(lvl[I_RXF]), .sdata(lvl[I_RXD]),
    .word(rx_word), .valid(rx_valid), .sig_out(rx_sig)
  );

  logic [1:0] fs_pair, sb_pair;
  assign fs_pair = {lvl[I_RXF], lvl[I_TXF]};

  for (genvar g = 0; g < 2; g++) begin : g_idle
    pcm_idle_timer #(.LIMIT(IDLE_LIMIT)) u_idle (
      .clk(clk), .rst(rst), .tick(rise[I_MCLK]), .fs(fs_pair[g]), .standby(sb_pair[g])
    );
  end

  assign tx_standby = sb_pair[0];
  assign rx_standby = sb_pair[1];
endmodule

// File: rtl/pcm_slot_port_chk.sv
`timescale 1ns/1ps
module pcm_slot_port_chk (
  input logic clk,
  input logic rst,
  input logic rate_var,
  input logic pwr_en,
  input logic tx_oe,
  input logic tx_strobe_n,
  input logic tx_load,
  input logic rx_valid,
  input logic tx_standby
);
  a_r2_valid_single: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);

  a_r6_strobe_in_window: assert property (@(posedge clk) disable iff (rst)
    !tx_strobe_n |-> tx_oe);

  a_r5_strobe_idle_var: assert property (@(posedge clk) disable iff (rst)
    (rate_var && $past(rate_var)) |-> tx_strobe_n);

  a_r7_load_with_start: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_oe) |-> tx_load);

  a_r7_load_only_start: assert property (@(posedge clk) disable iff (rst)
    tx_load |-> (tx_oe && !$past(tx_oe)));

  a_r9_powered_down_quiet: assert property (@(posedge clk) disable iff (rst)
    (!pwr_en && !$past(pwr_en) && !$past(pwr_en, 2)) |=> (!tx_oe && !rx_valid && !tx_load));

  a_r8_no_standby_in_slot: assert property (@(posedge clk) disable iff (rst)
    tx_standby |-> !tx_oe);
endmodule

bind pcm_slot_port pcm_slot_port_chk u_chk (
  .clk(clk), .rst(rst), .rate_var(rate_var), .pwr_en(pwr_en), .tx_oe(tx_oe),
  .tx_strobe_n(tx_strobe_n), .tx_load(tx_load), .rx_valid(rx_valid),
  .tx_standby(tx_standby)
);

// File: tb/tb_pcm_slot_port.sv
`timescale 1ns/1ps
module tb_pcm_slot_port;
  localparam int Q     = 80;   // quarter of master-clock period
  localparam int VQ    = 100;  // quarter of variable data-clock period
  localparam int LIMIT = 40;

  logic clk = 1'b0, rst = 1'b1;
  logic rate_var = 1'b0, pwr_en = 1'b1, mclk = 1'b0, dclk = 1'b0;
  logic tx_fsync = 1'b0, rx_fsync = 1'b0, tx_sig = 1'b0, rx_serial = 1'b0;
  logic [7:0] tx_sample = '0;
  logic tx_serial, tx_oe, tx_strobe_n, tx_load, rx_valid, rx_sig, tx_standby, rx_standby;
  logic [7:0] rx_word;

  int checks = 0, fails = 0, load_cnt = 0, valid_cnt = 0;
  logic [7:0] tx_q[$];
  logic [7:0] rx_q[$];

  pcm_slot_port #(.IDLE_LIMIT(LIMIT)) dut (
    .clk(clk), .rst(rst), .rate_var(rate_var), .pwr_en(pwr_en), .mclk(mclk),
    .tx_dclk(dclk), .rx_dclk(dclk), .tx_fsync(tx_fsync), .rx_fsync(rx_fsync),
    .tx_sig(tx_sig), .tx_sample(tx_sample), .tx_serial(tx_serial), .tx_oe(tx_oe),
    .tx_strobe_n(tx_strobe_n), .tx_load(tx_load), .rx_serial(rx_serial),
    .rx_word(rx_word), .rx_valid(rx_valid), .rx_sig(rx_sig),
    .tx_standby(tx_standby), .rx_standby(rx_standby)
  );

  always #10 clk = ~clk;
  initial begin #7; forever #(2*Q) mclk = ~mclk; end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: receive scoreboard and load counter
  always @(negedge clk) begin
    if (tx_load) load_cnt++;
    if (rx_valid) begin
      valid_cnt++;
      if (rx_q.size() == 0) chk(1'b0, "R2 unexpected word", rx_word, 0);
      else begin
        logic [7:0] e;
        e = rx_q.pop_front();
        chk(rx_word == e, "R2 rx word", rx_word, e);
      end
    end
  end

  task automatic tx_compare(input logic [7:0] got, input string req);
    logic [7:0] e;
    if (tx_q.size() == 0) begin chk(1'b0, req, got, 0); return; end
    e = tx_q.pop_front();
    chk(got == e, req, got, e);
  endtask

  task automatic fixed_frame(input logic [7:0] txw, input logic [7:0] rxw, input bit sig,
                             input bit sigv, input bit use_rx, input bit on);
    logic [7:0] got;
    int l0;
    got = '0;
    tx_sample = txw; tx_sig = sigv;
    if (on) begin
      tx_q.push_back(sig ? {txw[7:1], sigv} : txw);
      if (use_rx) rx_q.push_back(rxw);
    end
    l0 = load_cnt;
    @(posedge mclk); #(3*Q);
    tx_fsync = 1'b1; if (use_rx) rx_fsync = 1'b1;
    for (int k = 0; k < 8; k++) begin
      @(posedge mclk); #Q; rx_serial = rxw[7-k]; #(2*Q);
      got[7-k] = tx_serial;
      if (k == 3) begin
        if (on) begin
          chk(tx_oe == 1'b1, "R1 oe in window", tx_oe, 1);
          chk(tx_strobe_n == 1'b0, "R6 strobe low fixed", tx_strobe_n, 0);
        end else chk(tx_oe == 1'b0, "R9 oe held low", tx_oe, 0);
      end
      if ((k == 0 && !sig) || (k == 1 && sig)) begin tx_fsync = 1'b0; rx_fsync = 1'b0; end
    end
    @(posedge mclk); #(3*Q);
    chk(tx_oe == 1'b0, "R1 oe after window", tx_oe, 0);
    chk(tx_strobe_n == 1'b1, "R6 strobe released", tx_strobe_n, 1);
    if (on) begin
      tx_compare(got, sig ? "R3 tx signaling word" : "R1 tx word");
      chk(load_cnt - l0 == 1, "R7 one load per slot", load_cnt - l0, 1);
    end
  endtask

  task automatic var_frame(input logic [7:0] txw, input logic [7:0] rxw, input bit sigv);
    logic [7:0] got;
    int l0;
    got = '0;
    tx_sample = txw; tx_sig = sigv;
    tx_q.push_back(txw); rx_q.push_back(rxw);
    l0 = load_cnt;
    @(posedge mclk);
    for (int k = -1; k < 11; k++) begin
      dclk = 1'b1; #VQ;
      if (k >= 0 && k < 8) rx_serial = rxw[7-k];
      #VQ; dclk = 1'b0; #VQ;
      if (k >= 0 && k < 8) got[7-k] = tx_serial;
      if (k == 3) begin
        chk(tx_oe == 1'b1, "R5 oe in var slot", tx_oe, 1);
        chk(tx_strobe_n == 1'b1, "R5 strobe high var", tx_strobe_n, 1);
      end
      if (k == 8 || k == 9) chk(tx_oe == 1'b0, "R11 no restart while held", tx_oe, 0);
      if (k == -1) begin tx_fsync = 1'b1; rx_fsync = 1'b1; end
      if (k == 9)  begin tx_fsync = 1'b0; rx_fsync = 1'b0; end
      #VQ;
    end
    tx_compare(got, "R5 var word, no signaling");
    chk(load_cnt - l0 == 1, "R11 single load", load_cnt - l0, 1);
  endtask

  task automatic mclk_wait(input int n);
    for (int i = 0; i < n; i++) @(posedge mclk);
    #Q;
  endtask

  initial begin
    #2_000_000;
    chk(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int v0, l0;
    repeat (5) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(tx_oe == 0 && tx_load == 0, "R10 tx idle", {tx_oe, tx_load}, 0);
    chk(tx_strobe_n == 1, "R10 strobe", tx_strobe_n, 1);
    chk(rx_valid == 0 && rx_sig == 0 && rx_word == 0, "R10 rx idle", {rx_valid, rx_sig, rx_word}, 0);
    chk(tx_standby == 0 && rx_standby == 0, "R10 standby", {tx_standby, rx_standby}, 0);

    mclk_wait(2);
    fixed_frame(8'hA5, 8'h3C, 0, 1, 1, 1);      // R1 R2: tx_sig ignored in normal frame
    fixed_frame(8'hA4, 8'h81, 1, 1, 1, 1);      // R3: LSB replaced by 1
    mclk_wait(1);
    chk(rx_sig == 1'b1, "R4 sig captured", rx_sig, 1);
    fixed_frame(8'hFF, 8'h52, 0, 0, 1, 1);      // R3 normal: LSB kept
    mclk_wait(1);
    chk(rx_sig == 1'b1, "R4 sig held normal frame", rx_sig, 1);
    fixed_frame(8'h0F, 8'h7E, 1, 0, 1, 1);      // R3: LSB replaced by 0
    mclk_wait(1);
    chk(rx_sig == 1'b0, "R4 sig updated", rx_sig, 0);

    rate_var = 1'b1;
    var_frame(8'h96, 8'hC3, 1);                 // R5 R11
    var_frame(8'h01, 8'h80, 0);
    rate_var = 1'b0;

    // R8 standby
    mclk_wait(30);
    chk(tx_standby == 0 && rx_standby == 0, "R8 not yet standby", {tx_standby, rx_standby}, 0);
    mclk_wait(20);
    chk(tx_standby == 1 && rx_standby == 1, "R8 both standby", {tx_standby, rx_standby}, 3);
    fixed_frame(8'h5A, 8'h00, 0, 0, 0, 1);
    chk(tx_standby == 0, "R8 tx woken", tx_standby, 0);
    chk(rx_standby == 1, "R8 rx stays standby", rx_standby, 1);

    // R9 power-down
    pwr_en = 1'b0;
    mclk_wait(2);
    v0 = valid_cnt; l0 = load_cnt;
    fixed_frame(8'hC7, 8'h99, 0, 0, 1, 0);
    chk(valid_cnt == v0, "R9 no rx word", valid_cnt - v0, 0);
    chk(load_cnt == l0, "R9 no load", load_cnt - l0, 0);
    pwr_en = 1'b1;
    mclk_wait(2);
    fixed_frame(8'h3E, 8'h6D, 0, 0, 1, 1);
    mclk_wait(2);
    chk(rx_q.size() == 0, "R2 all words seen", rx_q.size(), 0);
    chk(tx_q.size() == 0, "R1 all words seen", tx_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule